// File: doc/BRIEF.md
# Display-Memory Write Command Parser

This block sits behind a serial receiver that has already assembled whole bytes from a select-framed serial link. It reads the byte stream of each frame and turns it into single-cycle write strobes for an on-screen display memory of 16 rows by 32 columns. The memory has two planes: one holds character codes and one holds attributes. Each strobe carries the row, column, plane and data byte.

A frame supports three packet styles. The first is row, then column, then data, repeated. The second sends one row and then column/data pairs. The third sends row, then column, then an unbroken run of data bytes, and the address steps forward by itself after each byte. The header bits of each byte tell the parser which kind of byte it is. Once a frame enters the run style, it stays in that style until the frame ends. Ending the frame sends the parser back to its start state.

The state machine has five states:
- `PS_IDLE` waits for a row byte.
- `PS_ROW` holds a row address.
- `PS_COL` holds a per-byte column address.
- `PS_NEXT` follows a per-byte data write.
- `PS_BURST` treats every byte as data.

Its transitions are:
- `PS_IDLE` to `PS_ROW` on a row byte.
- `PS_ROW` to `PS_ROW` on a further row byte.
- `PS_ROW` or `PS_NEXT` to `PS_COL` on a per-byte column.
- `PS_ROW` or `PS_NEXT` to `PS_BURST` on a run column.
- `PS_COL` to `PS_NEXT` on data.
- `PS_NEXT` to `PS_ROW` on a row byte.
- `PS_BURST` to `PS_BURST` on data.
- Any state to `PS_IDLE` when the frame ends.

Top module: `osd_wr_parser`

## Requirements
- R1: After reset, `wr_stb` is 0 and the parser is in its start state, waiting for a row byte.
- R2: A byte with bit 7 = 1, accepted in `PS_IDLE`, `PS_ROW` or `PS_NEXT`, sets the row to bits 3..0 and the plane to bit 5 (0 = code plane, 1 = attribute plane). Bits 6 and 4 have no effect.
- R3: A byte with bit 7 = 0, accepted in `PS_ROW` or `PS_NEXT`, sets the column to bits 4..0. If bit 6 is 1 the parser enters run mode; if bit 6 is 0 it stays in per-byte mode.
- R4: In per-byte mode, the byte that follows a column byte is data. One cycle after that byte is accepted, `wr_stb` is high for exactly one cycle, together with the held row, column and plane and that data byte.
- R5: After a per-byte data write, a byte with bit 7 = 0 is a new column within the same row and plane.
- R6: After a per-byte data write, a byte with bit 7 = 1 is a new row address.
- R7: In run mode, every byte is written to the current address, and then the column advances. Column 31 wraps to 0 and advances the row. Row 15 wraps to 0.
- R8: In run mode, bytes with bit 7 = 1 and bytes with bit 6 = 1 are still data. Run mode is never left while the frame stays active.
- R9: When `frame_act` falls, the parser returns to `PS_IDLE` and drops the row and column of any packet it had not finished. In `PS_IDLE`, a byte with bit 7 = 0 is ignored.
- R10: A byte offered while `frame_act` is 0 produces no write.
- R11: A second row byte directly after a row byte replaces the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_act | input | 1 | High while the serial select is asserted (frame in progress) |
| byte_vld | input | 1 | One-cycle pulse: `byte_in` holds a complete received byte |
| byte_in | input | 8 | Received byte, most significant bit first on the wire |
| wr_stb | output | 1 | Single-cycle write strobe to the display memory |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_plane | output | 1 | 0 = code plane, 1 = attribute plane |
| wr_data | output | 8 | Data byte of the write |

## Verification
The bench builds the block with its default geometry of 16 rows and 32 columns, so the address fields match the 4-bit row and 5-bit column fields of the header bytes exactly. With that geometry, a run that starts at row 15, column 30 needs only three bytes to cross both the column wrap and the row wrap. Frame drops between packets and in the middle of a packet show that partial addresses are discarded and that run mode ends with the frame.

// File: rtl/osd_wcp_pkg.sv
package osd_wcp_pkg;

    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_ROW   = 3'd1,
        PS_COL   = 3'd2,
        PS_NEXT  = 3'd3,
        PS_BURST = 3'd4
    } parse_st_e;

    // Fields pulled from one received byte
    typedef struct packed {
        logic is_row;
        logic is_burst;
        logic plane;
    } hdr_info_t;

endpackage

// File: rtl/wcp_hdr_decode.sv
module wcp_hdr_decode
    import osd_wcp_pkg::*;
#(
    parameter int RW = 4,
    parameter int CW = 5
) (
    input  logic [7:0]    hdr_byte,
    output hdr_info_t     info,
    output logic [RW-1:0] row_f,
    output logic [CW-1:0] col_f
);
    always_comb begin
        info.is_row   = hdr_byte[7];
        info.is_burst = hdr_byte[6];
        info.plane    = hdr_byte[5];
        row_f         = hdr_byte[RW-1:0];
        col_f         = hdr_byte[CW-1:0];
    end
endmodule

// File: rtl/wcp_fsm.sv
module wcp_fsm
    import osd_wcp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_act,
    input  logic      byte_vld,
    input  hdr_info_t info,
    output parse_st_e st_q,
    output logic      ld_row,
    output logic      ld_col,
    output logic      do_write,
    output logic      do_inc
);
    parse_st_e st_d;
    logic      take;

    assign take = frame_act && byte_vld;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        st_d     = st_q;
        ld_row   = 1'b0;
        ld_col   = 1'b0;
        do_write = 1'b0;
        do_inc   = 1'b0;
        if (!frame_act) begin
            st_d = PS_IDLE;
        end else if (take) begin
            unique case (st_q)
                PS_IDLE: begin
                    if (info.is_row) begin
                        ld_row = 1'b1;
                        st_d   = PS_ROW;
                    end
                end
                PS_ROW, PS_NEXT: begin
                    if (info.is_row) begin
                        ld_row = 1'b1;
                        st_d   = PS_ROW;
                    end else begin
                        ld_col = 1'b1;
                        st_d   = info.is_burst ? PS_BURST : PS_COL;
                    end
                end
                PS_COL: begin
                    do_write = 1'b1;
                    st_d     = PS_NEXT;
                end
                PS_BURST: begin
                    do_write = 1'b1;
                    do_inc   = 1'b1;
                end
                default: st_d = PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wcp_addr_gen.sv
module wcp_addr_gen #(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int RW   = 4,
    parameter int CW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_row,
    input  logic          ld_col,
    input  logic          do_inc,
    input  logic [RW-1:0] row_f,
    input  logic [CW-1:0] col_f,
    input  logic          plane_f,
    output logic [RW-1:0] row_q,
    output logic [CW-1:0] col_q,
    output logic          plane_q
);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            plane_q <= 1'b0;
        end else begin
            if (ld_row) begin
                row_q   <= row_f;
                plane_q <= plane_f;
            end
            if (ld_col) begin
                col_q <= col_f;
            end
            if (do_inc) begin
                if (col_q == COL_LAST) begin
                    col_q <= '0;
                    row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_wr_parser.sv
module osd_wr_parser
    import osd_wcp_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_act,
    input  logic          byte_vld,
    input  logic [7:0]    byte_in,
    output logic          wr_stb,
    output logic [RW-1:0] wr_row,
    output logic [CW-1:0] wr_col,
    output logic          wr_plane,
    output logic [7:0]    wr_data
);
    hdr_info_t     info;
    logic [RW-1:0] row_f, row_q;
    logic [CW-1:0] col_f, col_q;
    logic          plane_q;
    parse_st_e     st_q;
    logic          ld_row, ld_col, do_write, do_inc;

    wcp_hdr_decode #(.RW(RW), .CW(CW)) u_dec (
        .hdr_byte (byte_in),
        .info     (info),
        .row_f    (row_f),
        .col_f    (col_f)
    );

    wcp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (frame_act),
        .byte_vld  (byte_vld),
        .info      (info),
        .st_q      (st_q),
        .ld_row    (ld_row),
        .ld_col    (ld_col),
        .do_write  (do_write),
        .do_inc    (do_inc)
    );

    wcp_addr_gen #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_row  (ld_row),
        .ld_col  (ld_col),
        .do_inc  (do_inc),
        .row_f   (row_f),
        .col_f   (col_f),
        .plane_f (info.plane),
        .row_q   (row_q),
        .col_q   (col_q),
        .plane_q (plane_q)
    );

    // Registered write port: address captured before any increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb   <= 1'b0;
            wr_row   <= '0;
            wr_col   <= '0;
            wr_plane <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= do_write;
            if (do_write) begin
                wr_row   <= row_q;
                wr_col   <= col_q;
                wr_plane <= plane_q;
                wr_data  <= byte_in;
            end
        end
    end
endmodule

// File: rtl/osd_wr_parser_chk.sv
module osd_wr_parser_chk
    import osd_wcp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      frame_act,
    input logic      byte_vld,
    input logic      wr_stb,
    input parse_st_e st_q
);
    // R4: a strobe always follows a byte accepted inside a frame
    p_stb_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(byte_vld && frame_act));

    // R10: no write follows a cycle without an active frame
    p_quiet_unsel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!frame_act) |-> !wr_stb);

    // R9: frame end returns the parser to its start state
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> st_q == PS_IDLE);

    // R8: run mode holds while the frame stays active
    p_burst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_BURST && frame_act) |=> st_q == PS_BURST);
endmodule

bind osd_wr_parser osd_wr_parser_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_act (frame_act),
    .byte_vld  (byte_vld),
    .wr_stb    (wr_stb),
    .st_q      (st_q)
);

// File: tb/tb_osd_wr_parser.sv
module tb_osd_wr_parser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_act = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       wr_stb;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic       wr_plane;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected item: {row, col, plane, data}
    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    osd_wr_parser dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (frame_act),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .wr_stb    (wr_stb),
        .wr_row    (wr_row),
        .wr_col    (wr_col),
        .wr_plane  (wr_plane),
        .wr_data   (wr_data)
    );

    task automatic expect_wr(input string tag, input logic [3:0] r, input logic [4:0] c,
                             input logic p, input logic [7:0] d);
        exp_q.push_back({r, c, p, d});
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_in  = b;
        byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input logic on);
        @(negedge clk);
        frame_act = on;
        @(negedge clk);
    endtask

    // Byte that must not produce a write
    task automatic send_quiet(input string tag, input logic [7:0] b);
        @(negedge clk);
        byte_in  = b;
        byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        checks++;
        if (wr_stb !== 1'b0) begin
            errors++;
            $display("FAIL %s: wr_stb=%b expected 0", tag, wr_stb);
        end
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && wr_stb === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected write: row=%0d col=%0d plane=%0d data=%h expected none",
                         wr_row, wr_col, wr_plane, wr_data);
            end else begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({wr_row, wr_col, wr_plane, wr_data} !== e) begin
                    errors++;
                    $display("FAIL %s: got row=%0d col=%0d plane=%0d data=%h expected row=%0d col=%0d plane=%0d data=%h",
                             t, wr_row, wr_col, wr_plane, wr_data,
                             e[17:14], e[13:9], e[8], e[7:0]);
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (wr_stb !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: wr_stb=%b expected 0", wr_stb);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (wr_stb !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: wr_stb=%b expected 0", wr_stb);
        end

        frame(1'b1);
        // R4 per-byte triple
        expect_wr("R4 row/col/data", 4'd5, 5'd3, 1'b0, 8'hAA);
        send(8'h85); send(8'h03); send(8'hAA);
        // R5 new column after data
        expect_wr("R5 column after data", 4'd5, 5'd7, 1'b0, 8'h11);
        send(8'h07); send(8'h11);
        // R6 new row after data, attribute plane (R2 bit 5)
        expect_wr("R6 row after data", 4'd2, 5'd0, 1'b1, 8'h5C);
        send(8'hA2); send(8'h00); send(8'h5C);
        // R2 bits 6 and 4 ignored in row byte
        expect_wr("R2 header bits ignored", 4'd9, 5'd31, 1'b0, 8'h33);
        send(8'hD9); send(8'h1F); send(8'h33);
        // R11 second row byte replaces first
        expect_wr("R11 row replaced", 4'd12, 5'd4, 1'b0, 8'h77);
        send(8'h81); send(8'h8C); send(8'h04); send(8'h77);
        // R3 run column after per-byte data, R7 increment
        expect_wr("R3 per-byte before run", 4'd1, 5'd1, 1'b0, 8'h10);
        send(8'h81); send(8'h01); send(8'h10);
        expect_wr("R3 run entry", 4'd1, 5'd1, 1'b0, 8'h20);
        expect_wr("R7 run step", 4'd1, 5'd2, 1'b0, 8'h21);
        send(8'h41); send(8'h20); send(8'h21);
        frame(1'b0);

        // R7 wraps, R8 header-like data stays data
        frame(1'b1);
        expect_wr("R7 run start", 4'd15, 5'd30, 1'b1, 8'h01);
        expect_wr("R7 column end", 4'd15, 5'd31, 1'b1, 8'h02);
        expect_wr("R7 row wrap", 4'd0, 5'd0, 1'b1, 8'h03);
        expect_wr("R8 bit7 byte is data", 4'd0, 5'd1, 1'b1, 8'h90);
        expect_wr("R8 bit6 byte is data", 4'd0, 5'd2, 1'b1, 8'h45);
        send(8'hBF); send(8'h5E);
        send(8'h01); send(8'h02); send(8'h03); send(8'h90); send(8'h45);
        frame(1'b0);

        // R10 byte outside frame
        send_quiet("R10 byte outside frame", 8'h55);

        // R9 idle ignores column-like byte; partial row dropped
        frame(1'b1);
        send_quiet("R9 column byte in idle", 8'h12);
        send(8'h84);
        frame(1'b0);
        frame(1'b1);
        send_quiet("R9 partial row dropped", 8'h06);
        send_quiet("R9 still idle", 8'h99);
        expect_wr("R9 fresh packet", 4'd4, 5'd6, 1'b0, 8'h99);
        send(8'h84); send(8'h06); send(8'h99);
        frame(1'b0);

        // R9 run mode left at frame end
        frame(1'b1);
        send(8'h80); send(8'h40); 
        expect_wr("R9 run data", 4'd0, 5'd0, 1'b0, 8'hE1);
        send(8'hE1);
        frame(1'b0);
        frame(1'b1);
        expect_wr("R9 per-byte after run", 4'd3, 5'd2, 1'b0, 8'h44);
        send(8'h83); send(8'h02); send(8'h44);
        frame(1'b0);

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 missing writes: %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule